// File: doc/BRIEF.md
# Companion GPIO and Control Register Block

This block is a small register file for a peripheral companion device, sitting on a plain synchronous register bus. The bus has an address, a write enable, a read enable, write data and read data. The block holds the following registers:

- a mode register
- a card-detect register
- a card-control register
- a power register
- a fixed status word
- three interrupt-related words, which are storage only and drive nothing
- a 16-line general-purpose I/O port, made of a direction register and a level register

Each GPIO output pin carries its level bit gated by its direction bit. The pins are refreshed only when software writes the direction register or the level register. A change on an input pin moves the matching level bit, but it leaves the output pins alone until the next such write. Software reads the level register through either of two aliased offsets.

Only the low six address bits take part in decoding, so the map repeats through the rest of the address space. Write data is cut to 16 bits before it is stored. Read data is registered.

Top module: `companion_gpio_regs`

## Requirements
- R1: After reset the gpioOut pins are 0x0000. Every register reads 0x0000, except the status register at offset 0x08, which reads 0x0002.
- R2: The registers at offsets 0x00 (mode), 0x04 (card-detect), 0x10 (card-control), 0x14 (interrupt request), 0x18 (interrupt mask) and 0x1C (interrupt status) store bits 15:0 of the write data. A later read returns that value.
- R3: Only address bits 5:0 are decoded. Accesses that differ only in higher address bits reach the same register.
- R4: A write to the power register (0x0C) stores the 16-bit value. When bit 7 of that value is 1, bits 15 and 6 (mask 0x8040) are also set in the stored value.
- R5: The status register (0x08) always reads 0x0002, and bus writes to it have no effect.
- R6: A read of 0x20 returns the direction register. A write to 0x24 or to 0x28 stores the write data ANDed with the current direction register into the level register. A read of either 0x24 or 0x28 returns the level register.
- R7: After a write to 0x20, 0x24 or 0x28, gpioOut equals (level AND direction) as those registers stand after the write. gpioOut takes this value on the same clock edge that updates the registers.
- R8: When gpioIn[i] differs from its value in the previous cycle, level bit i takes the new input value at the next clock edge. gpioOut does not change because of an input change.
- R9: A read of an unmapped offset returns 0x0000. A write to an unmapped offset changes no register and no output.
- R10: Read data is registered. rdData shows the selected register on the clock edge that samples rdEn, and it holds its value while rdEn is low.
- R11: When a level write and an input change hit the same bit in the same cycle, the bus write decides that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address; bits 5:0 are decoded |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | BUS_W | Write data; bits 15:0 are used |
| rdData | output | 16 | Registered read data |
| gpioIn | input | 16 | GPIO input lines |
| gpioOut | output | 16 | GPIO output lines (level AND direction) |

## Verification
Every result in this block is due exactly one clock edge after the cycle that causes it:

- Read data appears at the edge that samples rdEn.
- Register contents and gpioOut change at the edge that samples a write.
- A level bit follows an input change at the edge that samples the new input.

The bench drives each cycle's stimulus on the falling edge. It advances its own expected register image once per rising edge, then compares rdData and gpioOut on the following falling edge. The bench never waits a variable time, so an off-by-one-cycle fault shows up as a mismatch.

// File: rtl/companion_regs_pkg.sv
package companion_regs_pkg;
  localparam int REG_W = 16;
  localparam int DEC_W = 6;

  localparam logic [DEC_W-1:0] OFF_MODE = 6'h00;
  localparam logic [DEC_W-1:0] OFF_CDET = 6'h04;
  localparam logic [DEC_W-1:0] OFF_STAT = 6'h08;
  localparam logic [DEC_W-1:0] OFF_PWR  = 6'h0C;
  localparam logic [DEC_W-1:0] OFF_CCTL = 6'h10;
  localparam logic [DEC_W-1:0] OFF_IREQ = 6'h14;
  localparam logic [DEC_W-1:0] OFF_IMSK = 6'h18;
  localparam logic [DEC_W-1:0] OFF_ISTS = 6'h1C;
  localparam logic [DEC_W-1:0] OFF_DIR  = 6'h20;
  localparam logic [DEC_W-1:0] OFF_LVLA = 6'h24;
  localparam logic [DEC_W-1:0] OFF_LVLB = 6'h28;

  localparam logic [REG_W-1:0] STATUS_VALUE = 16'h0002;
  localparam int               PWR_TRIG_BIT = 7;
  localparam logic [REG_W-1:0] PWR_FORCE    = 16'h8040;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MODE, SEL_CDET, SEL_STAT, SEL_PWR, SEL_CCTL,
    SEL_IREQ, SEL_IMSK, SEL_ISTS, SEL_DIR, SEL_LVL
  } regSel_e;

  typedef struct packed {
    logic    wrMode;
    logic    wrCdet;
    logic    wrPwr;
    logic    wrCctl;
    logic    wrIreq;
    logic    wrImsk;
    logic    wrIsts;
    logic    wrDir;
    logic    wrLvl;
    logic    rdEn;
    regSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/companion_regs_ctrl.sv
module companion_regs_ctrl
  import companion_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output regStrobe_t        stb
);
  logic [DEC_W-1:0] decAddr;
  logic             unusedAddrHi;
  regSel_e          sel;

  assign decAddr      = addr[DEC_W-1:0];
  assign unusedAddrHi = ^addr[ADDR_W-1:DEC_W];

  always_comb begin
    case (decAddr)
      OFF_MODE: sel = SEL_MODE;
      OFF_CDET: sel = SEL_CDET;
      OFF_STAT: sel = SEL_STAT;
      OFF_PWR:  sel = SEL_PWR;
      OFF_CCTL: sel = SEL_CCTL;
      OFF_IREQ: sel = SEL_IREQ;
      OFF_IMSK: sel = SEL_IMSK;
      OFF_ISTS: sel = SEL_ISTS;
      OFF_DIR:  sel = SEL_DIR;
      OFF_LVLA: sel = SEL_LVL;
      OFF_LVLB: sel = SEL_LVL;
      default:  sel = SEL_NONE;
    endcase
  end

  always_comb begin
    stb        = '0;
    stb.rdEn   = rdEn;
    stb.rdSel  = sel;
    stb.wrMode = wrEn && (sel == SEL_MODE);
    stb.wrCdet = wrEn && (sel == SEL_CDET);
    stb.wrPwr  = wrEn && (sel == SEL_PWR);
    stb.wrCctl = wrEn && (sel == SEL_CCTL);
    stb.wrIreq = wrEn && (sel == SEL_IREQ);
    stb.wrImsk = wrEn && (sel == SEL_IMSK);
    stb.wrIsts = wrEn && (sel == SEL_ISTS);
    stb.wrDir  = wrEn && (sel == SEL_DIR);
    stb.wrLvl  = wrEn && (sel == SEL_LVL);
  end
endmodule

// File: rtl/companion_regs_dp.sv
module companion_regs_dp
  import companion_regs_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       stb,
  input  logic [BUS_W-1:0] wrData,
  input  logic [REG_W-1:0] gpioIn,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] gpioOut
);
  logic [REG_W-1:0] wrVal;
  logic             unusedDataHi;
  logic [REG_W-1:0] modeQ, cdetQ, pwrQ, cctlQ, ireqQ, imskQ, istsQ;
  logic [REG_W-1:0] dirQ, lvlQ, prevInQ, outQ, rdQ;
  logic [REG_W-1:0] dirNext, lvlNext, inEdge, pwrVal, rdMux;

  assign wrVal        = wrData[REG_W-1:0];
  assign unusedDataHi = ^wrData[BUS_W-1:REG_W];
  assign pwrVal       = wrVal | (wrVal[PWR_TRIG_BIT] ? PWR_FORCE : '0);
  assign inEdge       = gpioIn ^ prevInQ;
  assign dirNext      = stb.wrDir ? wrVal : dirQ;

  // Per-line level update: bus write first, then input change, else hold.
  for (genvar i = 0; i < REG_W; i++) begin : g_line
    always_comb begin
      if (stb.wrLvl)      lvlNext[i] = wrVal[i] & dirQ[i];
      else if (inEdge[i]) lvlNext[i] = gpioIn[i];
      else                lvlNext[i] = lvlQ[i];
    end
  end

  always_comb begin
    case (stb.rdSel)
      SEL_MODE: rdMux = modeQ;
      SEL_CDET: rdMux = cdetQ;
      SEL_STAT: rdMux = STATUS_VALUE;
      SEL_PWR:  rdMux = pwrQ;
      SEL_CCTL: rdMux = cctlQ;
      SEL_IREQ: rdMux = ireqQ;
      SEL_IMSK: rdMux = imskQ;
      SEL_ISTS: rdMux = istsQ;
      SEL_DIR:  rdMux = dirQ;
      SEL_LVL:  rdMux = lvlQ;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0; cdetQ <= '0; pwrQ <= '0; cctlQ <= '0;
      ireqQ <= '0; imskQ <= '0; istsQ <= '0;
      dirQ <= '0; lvlQ <= '0; prevInQ <= '0; outQ <= '0; rdQ <= '0;
    end else begin
      if (stb.wrMode) modeQ <= wrVal;
      if (stb.wrCdet) cdetQ <= wrVal;
      if (stb.wrPwr)  pwrQ  <= pwrVal;
      if (stb.wrCctl) cctlQ <= wrVal;
      if (stb.wrIreq) ireqQ <= wrVal;
      if (stb.wrImsk) imskQ <= wrVal;
      if (stb.wrIsts) istsQ <= wrVal;
      dirQ    <= dirNext;
      lvlQ    <= lvlNext;
      prevInQ <= gpioIn;
      if (stb.wrDir || stb.wrLvl) outQ <= lvlNext & dirNext;
      if (stb.rdEn) rdQ <= rdMux;
    end
  end

  assign rdData  = rdQ;
  assign gpioOut = outQ;
endmodule

// File: rtl/companion_gpio_regs.sv
module companion_gpio_regs
  import companion_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BUS_W-1:0]  wrData,
  output logic [15:0]       rdData,
  input  logic [15:0]       gpioIn,
  output logic [15:0]       gpioOut
);
  regStrobe_t stb;

  companion_regs_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .stb(stb)
  );

  companion_regs_dp #(.BUS_W(BUS_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .gpioIn(gpioIn), .rdData(rdData), .gpioOut(gpioOut)
  );
endmodule

// File: rtl/companion_regs_checker.sv
module companion_regs_checker #(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [BUS_W-1:0]  wrData,
  input logic [15:0]       rdData,
  input logic [15:0]       gpioIn,
  input logic [15:0]       gpioOut
);
  logic [5:0] low;
  logic       mapped, gpioWr, unusedIn;
  assign low      = addr[5:0];
  assign mapped   = (low[1:0] == 2'b00) && (low <= 6'h28);
  assign gpioWr   = wrEn && (low == 6'h20 || low == 6'h24 || low == 6'h28);
  assign unusedIn = ^gpioIn;

  assert_status_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && low == 6'h08) |=> rdData == 16'h0002);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mapped) |=> rdData == 16'h0000);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  assert_out_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !gpioWr |=> $stable(gpioOut));

  assert_out_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && low == 6'h20) |=> (gpioOut & ~$past(wrData[15:0])) == 16'h0000);
endmodule

bind companion_gpio_regs companion_regs_checker #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) i_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .gpioIn(gpioIn), .gpioOut(gpioOut)
);

// File: tb/test_companion_gpio_regs.sv
`timescale 1ns/1ps
module test_companion_gpio_regs;
  localparam int ADDR_W = 12;
  localparam int BUS_W  = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wrEn = 1'b0, rdEn = 1'b0;
  logic [BUS_W-1:0]  wrData = '0;
  logic [15:0]       rdData, gpioIn = '0, gpioOut;

  int checks = 0, fails = 0;
  bit done = 0;

  // Expected register image
  logic [15:0] mMode, mCdet, mPwr, mCctl, mIreq, mImsk, mIsts, mDir, mLvl, mOut, mPrev, mRd;

  companion_gpio_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) i_companion_gpio_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .gpioIn(gpioIn), .gpioOut(gpioOut)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] expRead(logic [5:0] low);
    case (low)
      6'h00: return mMode;
      6'h04: return mCdet;
      6'h08: return 16'h0002;
      6'h0C: return mPwr;
      6'h10: return mCctl;
      6'h14: return mIreq;
      6'h18: return mImsk;
      6'h1C: return mIsts;
      6'h20: return mDir;
      6'h24, 6'h28: return mLvl;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mMode = 0; mCdet = 0; mPwr = 0; mCctl = 0; mIreq = 0; mImsk = 0; mIsts = 0;
    mDir = 0; mLvl = 0; mOut = 0; mPrev = 0; mRd = 0;
  endtask

  // One bus cycle, driven at a falling edge; checks at the next falling edge.
  task automatic step(string req, logic [ADDR_W-1:0] a, logic we, logic re,
                      logic [BUS_W-1:0] wd, logic [15:0] gin);
    logic [5:0]  low;
    logic [15:0] v, nDir, nLvl, edges;
    addr = a; wrEn = we; rdEn = re; wrData = wd; gpioIn = gin;
    low = a[5:0]; v = wd[15:0];
    if (re) mRd = expRead(low);
    edges = gin ^ mPrev;
    nLvl  = (mLvl & ~edges) | (gin & edges);           // R8
    nDir  = mDir;
    if (we) begin
      case (low)
        6'h00: mMode = v;
        6'h04: mCdet = v;
        6'h0C: mPwr  = v[7] ? (v | 16'h8040) : v;       // R4
        6'h10: mCctl = v;
        6'h14: mIreq = v;
        6'h18: mImsk = v;
        6'h1C: mIsts = v;
        6'h20: nDir  = v;
        6'h24, 6'h28: nLvl = v & mDir;                  // R6, R11
        default: ;
      endcase
      if (low == 6'h20 || low == 6'h24 || low == 6'h28) mOut = nLvl & nDir; // R7
    end
    mDir = nDir; mLvl = nLvl; mPrev = gin;
    @(posedge clk);
    @(negedge clk);
    check({req, " rdData R10"}, rdData, mRd);
    check({req, " gpioOut R7"}, gpioOut, mOut);
    wrEn = 0; rdEn = 0;
  endtask

  task automatic wr(string req, logic [ADDR_W-1:0] a, logic [31:0] d);
    step(req, a, 1'b1, 1'b0, d, gpioIn);
  endtask

  task automatic rdChk(string req, logic [ADDR_W-1:0] a, logic [15:0] exp);
    step(req, a, 1'b0, 1'b1, 32'h0, gpioIn);
    check(req, rdData, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1 out", gpioOut, 16'h0000);
    for (int k = 0; k <= 10; k++)
      rdChk("R1 reset read", ADDR_W'(k * 4), (k == 2) ? 16'h0002 : 16'h0000);

    // R2 plain storage with truncation
    wr("R2", 12'h000, 32'hABCD_1234); rdChk("R2 mode", 12'h000, 16'h1234);
    wr("R2", 12'h004, 32'h0000_BEEF); rdChk("R2 cdet", 12'h004, 16'hBEEF);
    wr("R2", 12'h010, 32'h0000_0F0F); rdChk("R2 cctl", 12'h010, 16'h0F0F);
    wr("R2", 12'h014, 32'h0000_1111); rdChk("R2 ireq", 12'h014, 16'h1111);
    wr("R2", 12'h018, 32'h0000_2222); rdChk("R2 imsk", 12'h018, 16'h2222);
    wr("R2", 12'h01C, 32'h0000_3333); rdChk("R2 ists", 12'h01C, 16'h3333);
    // R3 aliasing through upper address bits
    wr("R3", 12'hFC0, 32'h0000_5A5A); rdChk("R3 alias", 12'h440, 16'h5A5A);
    // R4 power forcing
    wr("R4", 12'h00C, 32'h0000_0080); rdChk("R4 forced", 12'h00C, 16'h80C0);
    wr("R4", 12'h00C, 32'h0000_0101); rdChk("R4 plain", 12'h00C, 16'h0101);
    // R5 status ignores writes
    wr("R5", 12'h008, 32'h0000_FFFF); rdChk("R5 status", 12'h008, 16'h0002);
    // R9 unmapped
    wr("R9", 12'h02C, 32'h0000_FFFF); rdChk("R9 unmapped", 12'h02C, 16'h0000);
    rdChk("R9 misaligned", 12'h001, 16'h0000);
    rdChk("R9 mode kept", 12'h000, 16'h5A5A);
    // R6 / R7 GPIO
    wr("R6", 12'h024, 32'h0000_FFFF); rdChk("R6 masked by dir0", 12'h024, 16'h0000);
    wr("R7", 12'h020, 32'h0000_00FF); check("R7 dir out", gpioOut, 16'h0000);
    wr("R6", 12'h028, 32'h0000_0F3C); rdChk("R6 alias read", 12'h024, 16'h003C);
    check("R7 out", gpioOut, 16'h003C);
    rdChk("R6 dir read", 12'h020, 16'h00FF);
    // R8 input change moves level but not outputs
    step("R8", 12'h03C, 1'b0, 1'b0, 32'h0, 16'h0003);
    check("R8 out unchanged", gpioOut, 16'h003C);
    rdChk("R8 level", 12'h028, 16'h003F);
    wr("R8", 12'h020, 32'h0000_00FF); check("R8 dir refresh", gpioOut, 16'h003F);
    // R11 write wins over same-cycle input change
    step("R11", 12'h024, 1'b1, 1'b0, 32'h0000_0000, 16'h0000);
    rdChk("R11 level", 12'h024, 16'h0000);
    // R10 hold
    step("R10 hold", 12'h000, 1'b0, 1'b0, 32'h0, gpioIn);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [ADDR_W-1:0] a;
      logic [15:0] g;
      a = ($urandom % 4 == 0) ? ADDR_W'($urandom) : ADDR_W'(($urandom % 12) * 4);
      g = ($urandom % 4 == 0) ? 16'($urandom) : gpioIn;
      step("RND R2 R6 R8", a, 1'($urandom), 1'($urandom), $urandom, g);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule